// File: doc/BRIEF.md
# MDIO Management Access Engine

This block is a management-bus master that runs one clause-22 transaction against an external PHY each time software asks for one. Software sees a single 32-bit command word. It holds a start flag, a direction select, an acknowledge status, the target PHY and register addresses, and a 16-bit data field. Software loads the addresses, direction and data, and sets the start flag in the same write. The engine then waits for a convenient MDC falling edge and shifts the whole frame out on MDIO. For a read, it takes back the acknowledge and the returned data. When the frame is over, it clears the start flag.

MDC is a free-running clock divided from the system clock by a programmable even ratio. MDIO has a separate output value and output enable, so a pad tristate can be built from them. While a command is pending, writes to the command word cannot change it. Software therefore polls the start flag, or the busy output, before it issues the next access.

Top module: `mdio_access_engine`

## Requirements
- R1: After reset the command word reads as zero. The word is packed as {start[31], direction[30], ack[29], 3'b000[28:26], reg_addr[25:21], phy_addr[20:16], data[15:0]}, and bits 28–26 always read zero.
- R2: A write with bit 31 = 1 sets the start flag only while `en` is high. If `en` is low, or bit 31 is 0, the flag stays 0 and no frame is sent. The other fields still load.
- R3: The start flag clears by itself one MDC falling edge after the last data bit. `done` is high for exactly one system clock in that same cycle, and `busy` always equals the start flag.
- R4: While the start flag is 1, every write to the command word is discarded, and no field changes except through the running transaction.
- R5: A write frame (direction = 1) drives, MSB first: 32 ones, 01, opcode 01, phy_addr, reg_addr, turnaround 10, then the 16 data bits. All 64 bits are driven.
- R6: A read frame (direction = 0) sends opcode 10 and releases `mdio_oe` from the turnaround onward, which is frame bit 46. The 16 bits sampled afterwards, MSB first, replace the data field.
- R7: The ack bit is set when the PHY holds MDIO low during the second turnaround bit of a read. Otherwise it is cleared, and it is always cleared by a write frame.
- R8: MDC high and low phases each last `mdc_half` system clocks, with a value of 0 treated as 1. MDIO output changes only on MDC falling edges, and input is sampled on MDC rising edges.
- R9: `mdio_oe` is low whenever no transaction is pending, so the line is released after every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; gates setting of the start flag |
| wr_en | input | 1 | Command word write strobe |
| wdata | input | 32 | Command word write data |
| rdata | output | 32 | Command word read value |
| mdc_half | input | DIV_W | MDC half period in system clocks |
| busy | output | 1 | Start flag mirror |
| done | output | 1 | One-cycle pulse when a transaction finishes |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench aims at the start-flag corners. It tries to start an access with the engine disabled, which a faulty design would answer with a stray frame, and it overwrites a pending command, which a faulty design would let change the addresses or data in mid-frame. A PHY model decodes every frame bit on MDC rising edges. It catches a wrong opcode, a wrong address order, an off-by-one turnaround, or an output enable that is still driving when the PHY answers. Reads are run with and without a responding PHY, which exposes an ack taken from the wrong bit and data that is shifted by one place. The MDC half period is measured for ratios 0, 1 and 3, so a divider that miscounts shows up as a wrong phase length.

// File: rtl/mdio_access_engine.sv
module mdio_access_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [DIV_W-1:0] mdc_half,
  output logic             busy,
  output logic             done,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int FRAME   = 64;
  localparam int TA_BIT  = 46;
  localparam int ACK_BIT = TA_BIT + 1;
  localparam int DAT_BIT = TA_BIT + 2;
  localparam int CW      = $clog2(FRAME);

  logic             go, wsel, ack, active;
  logic [4:0]       regad, phyad;
  logic [15:0]      data;
  logic [CW-1:0]    bitn;
  logic [FRAME-1:0] sh;
  logic [DIV_W-1:0] cnt, lim;
  logic             tick, fall, rise;

  assign lim  = (mdc_half == '0) ? '0 : mdc_half - DIV_W'(1);
  assign tick = (cnt >= lim);
  assign fall = tick & mdc;
  assign rise = tick & ~mdc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      go <= 1'b0; wsel <= 1'b0; ack <= 1'b0; active <= 1'b0;
      regad <= '0; phyad <= '0; data <= '0;
      bitn <= '0; sh <= '0; mdio_oe <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wr_en && !go) begin
        go    <= wdata[31] & en;
        wsel  <= wdata[30];
        regad <= wdata[25:21];
        phyad <= wdata[20:16];
        data  <= wdata[15:0];
      end
      if (fall) begin
        if (!active && go) begin
          active  <= 1'b1;
          bitn    <= '0;
          sh      <= {32'hFFFF_FFFF, 2'b01, wsel ? 2'b01 : 2'b10, phyad, regad, 2'b10, data};
          mdio_oe <= 1'b1;
          ack     <= 1'b0;
        end else if (active) begin
          if (bitn == CW'(FRAME - 1)) begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
            go      <= 1'b0;
            done    <= 1'b1;
          end else begin
            bitn <= bitn + CW'(1);
            sh   <= {sh[FRAME-2:0], 1'b1};
            if (!wsel && bitn == CW'(TA_BIT - 1)) mdio_oe <= 1'b0;
          end
        end
      end
      if (rise && active && !wsel) begin
        if (bitn == CW'(ACK_BIT)) ack <= ~mdio_i;
        else if (bitn >= CW'(DAT_BIT)) data <= {data[14:0], mdio_i};
      end
    end

  assign mdio_o = sh[FRAME-1];
  assign busy   = go;
  assign rdata  = {go, wsel, ack, 3'b000, regad, phyad, data};

  p_go_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go) |-> $past(en) && $past(wr_en));
  p_done_clears_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !go && $past(go));
  p_write_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go && wr_en |=> phyad == $past(phyad) && regad == $past(regad) && wsel == $past(wsel));
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe && active && !wsel |-> bitn < CW'(TA_BIT));
  p_mdio_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));
  p_released_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !mdio_oe);
endmodule

// File: tb/sim_mdio_access_engine.sv
module sim_mdio_access_engine;
  logic        clk = 0, rst_n = 0, en = 0, wr_en = 0, mdio_i = 1;
  logic [31:0] wdata = 0, rdata;
  logic [7:0]  mdc_half = 8'd2;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  int          checks = 0, fails = 0;

  mdio_access_engine #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .mdc_half(mdc_half), .busy(busy), .done(done), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #10 clk = ~clk;

  logic        cap_bit [64];
  logic        cap_oe  [64];
  int          idx = 0;
  logic        inframe = 0;
  int          frames = 0;
  logic        phy_ack = 1;
  logic [15:0] phy_data = 0;

  always @(posedge mdc) begin
    if (!inframe && mdio_oe) begin inframe = 1; idx = 0; frames++; end
    else if (inframe) idx++;
    if (inframe) begin
      cap_bit[idx] = mdio_o;
      cap_oe[idx]  = mdio_oe;
      if (idx == 63) inframe = 0;
    end
  end

  always @(negedge mdc) begin
    int nb;
    nb = idx + 1;
    if (!inframe || !phy_ack) mdio_i = 1'b1;
    else if (nb == 47) mdio_i = 1'b0;
    else if (nb >= 48 && nb <= 63) mdio_i = phy_data[63-nb];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic g, input logic w, input logic [4:0] ra,
                                           input logic [4:0] pa, input logic [15:0] d);
    return {g, w, 1'b0, 3'b000, ra, pa, d};
  endfunction

  function automatic logic [63:0] frame_of(input logic w, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, pa, ra, 2'b10, d};
  endfunction

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk); wr_en = 1; wdata = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure_half(input logic [7:0] h, input int exp);
    int n;
    mdc_half = h;
    @(posedge mdc); @(posedge mdc);
    n = 0;
    while (mdc) begin @(posedge clk); #1; n++; end
    chk("R8 half period", 64'(n), 64'(exp));
  endtask

  task automatic run(input logic w, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] d, input logic pack, input logic [15:0] pdat);
    int dn, t, f0;
    logic [63:0] ef;
    logic        ok, oe_ok;
    logic        ea;
    logic [15:0] ed;
    phy_ack = pack; phy_data = pdat;
    f0 = frames;
    write_cmd(cmd_word(1'b1, w, ra, pa, d));
    chk("R3 busy mirrors start", {63'd0, busy}, 64'd1);
    write_cmd(cmd_word(1'b1, ~w, ~ra, ~pa, ~d));
    dn = 0; t = 0;
    do begin @(negedge clk); if (done) dn++; t++; end while (busy && t < 20000);
    @(negedge clk); if (done) dn++;
    chk("R3 single done pulse", 64'(dn), 64'd1);
    chk("R3 one frame per command", 64'(frames - f0), 64'd1);
    chk("R9 released after frame", {63'd0, mdio_oe}, 64'd0);
    ef = frame_of(w, pa, ra, d);
    ok = 1; oe_ok = 1;
    for (int i = 0; i < 46; i++) if (cap_bit[i] !== ef[63-i] || cap_oe[i] !== 1'b1) ok = 0;
    if (w) begin
      for (int i = 46; i < 64; i++) if (cap_bit[i] !== ef[63-i] || cap_oe[i] !== 1'b1) ok = 0;
      chk("R5 write frame bits", {63'd0, ok}, 64'd1);
    end else begin
      for (int i = 46; i < 64; i++) if (cap_oe[i] !== 1'b0) oe_ok = 0;
      chk("R6 read header bits", {63'd0, ok}, 64'd1);
      chk("R6 oe released from turnaround", {63'd0, oe_ok}, 64'd1);
    end
    ea = w ? 1'b0 : pack;
    ed = w ? d : (pack ? pdat : 16'hFFFF);
    chk(w ? "R4 fields kept after blocked write" : "R7 ack and R6 read data",
        64'(rdata), 64'({1'b0, w, ea, 3'b000, ra, pa, ed}));
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<190000", wd);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] seedv;
    seedv = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1 reset word", 64'(rdata), 64'd0);
    chk("R9 oe low after reset", {63'd0, mdio_oe}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 word zero out of reset", 64'(rdata), 64'd0);

    en = 0;
    write_cmd(32'hFFFF_FFFF);
    chk("R2 start blocked when disabled", 64'(rdata),
        64'(cmd_word(1'b0, 1'b1, 5'h1F, 5'h1F, 16'hFFFF)));
    repeat (600) @(negedge clk);
    chk("R2 no frame when disabled", 64'(frames), 64'd0);
    en = 1;
    write_cmd(cmd_word(1'b0, 1'b0, 5'h0A, 5'h05, 16'h1234));
    repeat (600) @(negedge clk);
    chk("R2 zero start has no effect", {frames[31:0], 31'd0, busy}, 64'd0);
    chk("R1 fields loaded", 64'(rdata), 64'(cmd_word(1'b0, 1'b0, 5'h0A, 5'h05, 16'h1234)));

    measure_half(8'd0, 1);
    measure_half(8'd1, 1);
    measure_half(8'd3, 3);

    mdc_half = 8'd1;
    run(1'b1, 5'h00, 5'h00, 16'h0000, 1'b1, 16'h0);
    run(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 1'b1, 16'h0);
    run(1'b0, 5'h11, 5'h03, 16'h0000, 1'b1, 16'hA5C3);
    run(1'b0, 5'h02, 5'h1E, 16'h5555, 1'b0, 16'h1234);

    for (int k = 0; k < 10; k++) begin
      logic [31:0] r;
      r = $urandom;
      mdc_half = 8'($urandom_range(0, 4));
      run(r[0], r[5:1], r[10:6], r[26:11], r[27] | r[28], 16'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule